// File: doc/BRIEF.md
# Transition-Filtered Status Register Set

This block is one register group of an instrument-style status model. It samples a vector of live condition inputs every clock, detects rising and falling changes on each bit, and latches an event bit only when that bit's edge direction is selected. Each bit has two direction masks, one for rising changes and one for falling changes. Latched events stay set until software reads the event register or the status model is reset. An enable mask picks which latched events contribute to a single summary output. That output is meant to be wired into one condition input of a higher-level group, so that events cascade toward a top-level status byte.

Software reaches the five registers through a plain register bus with address, write strobe, read strobe, write data and read data. Read data always shows the register at the current address. Only a read strobe aimed at the event register has a side effect, and that side effect is the clear. A synchronous status-model reset puts every register into a known state.

Top module: `stat_regset`

## Requirements
- R1: The condition register (address 0) returns the condition inputs as sampled at the previous rising clock edge. Bus writes to address 0 have no effect.
- R2: When a bit's rising mask (address 4) is 1 and that condition input changes from 0 to 1, the matching event bit (address 2) is 1 in the following cycle.
- R3: When a bit's falling mask (address 3) is 1 and that condition input changes from 1 to 0, the matching event bit is 1 in the following cycle. An edge whose direction mask bit is 0 sets nothing.
- R4: A set event bit stays set until a read strobe is given at address 2 or the status model is reset. Non-strobed reads at address 2, strobed reads at other addresses, and further edges do not clear it.
- R5: Bus writes to the event register address have no effect on its contents.
- R6: The summary output is 1 exactly when some bit is 1 in both the event register and the enable mask (address 1). It changes in the same cycle that either register is updated.
- R7: A read strobe at address 2 returns the event contents from before the edge. If a qualifying edge arrives in that same cycle, every old bit is cleared and the new bit is left set.
- R8: Status-model reset (sm_rst high at a clock edge) clears the event register, the enable mask and the falling mask, and sets every rising-mask bit to 1. It takes priority over a bus write in the same cycle, and edges seen while it is held are not latched.
- R9: Read data at an unmapped address (5 and above) is 0, and writes to unmapped addresses change no register.
- R10: The enable, falling and rising masks each read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; condition inputs are synchronous to it |
| sm_rst | input | 1 | Synchronous status-model reset, active high |
| cond_in | input | WIDTH | Live condition inputs |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; at address 2 it clears the event register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the current address, combinational |
| summary | output | 1 | OR over event bits gated by the enable mask |

## Verification
The clearing read of the event register and the latching of a new qualifying edge can land on the same clock edge. The bench provokes this by raising a second condition bit in the very cycle that it asserts the read strobe at address 2. It then judges the returned data against the old event contents and the next cycle's contents against only the new bit. A status-model reset coinciding with an enable write and with condition changes is exercised the same way, with reset expected to win.

// File: rtl/stat_regset_pkg.sv
package stat_regset_pkg;

   // Register map; the bus decode and the checker both depend on these.
   localparam int unsigned SR_ADDR_COND = 0;
   localparam int unsigned SR_ADDR_EN   = 1;
   localparam int unsigned SR_ADDR_EVT  = 2;
   localparam int unsigned SR_ADDR_FALL = 3;
   localparam int unsigned SR_ADDR_RISE = 4;
   localparam int unsigned SR_ADDR_LAST = SR_ADDR_RISE;

   // Smallest address width that reaches every mapped register.
   localparam int unsigned SR_MIN_ADDR_W = $clog2(SR_ADDR_LAST + 1);

endpackage

// File: rtl/stat_cond_track.sv
module stat_cond_track #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] cond_in,
   output logic [WIDTH-1:0] cond_q,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);

   // The copy tracks the inputs even during reset, so no edge is invented
   // when reset releases.
   always_ff @(posedge clk) begin
      cond_q <= cond_in;
   end

   assign rise = cond_in & ~cond_q;
   assign fall = ~cond_in & cond_q;

endmodule

// File: rtl/stat_mask_reg.sv
module stat_mask_reg #(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned SEL_ADDR   = 1,
   parameter bit          RESET_ONES = 1'b0
) (
   input  logic              clk,
   input  logic              sm_rst,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  mask_q
);

   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SEL_ADDR);
   localparam logic [WIDTH-1:0]  RST_VAL = RESET_ONES ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

   logic hit;
   assign hit = bus_wr && (bus_addr == MY_ADDR);

   always_ff @(posedge clk) begin
      if (sm_rst) begin
         mask_q <= RST_VAL;
      end else if (hit) begin
         mask_q <= bus_wdata;
      end
   end

endmodule

// File: rtl/stat_event_latch.sv
module stat_event_latch #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             sm_rst,
   input  logic             clr_rd,
   input  logic [WIDTH-1:0] rise,
   input  logic [WIDTH-1:0] fall,
   input  logic [WIDTH-1:0] rise_mask,
   input  logic [WIDTH-1:0] fall_mask,
   output logic [WIDTH-1:0] ev_q
);

   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] ev_d;

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      // New edges override the clearing read: old bits drop, new bits stay.
      assign hit[g]  = (rise[g] & rise_mask[g]) | (fall[g] & fall_mask[g]);
      assign ev_d[g] = (ev_q[g] & ~clr_rd) | hit[g];
   end

   always_ff @(posedge clk) begin
      if (sm_rst) begin
         ev_q <= '0;
      end else begin
         ev_q <= ev_d;
      end
   end

endmodule

// File: rtl/stat_regset.sv
module stat_regset #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              sm_rst,
   input  logic [WIDTH-1:0]  cond_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic              summary
);

   import stat_regset_pkg::*;

   localparam logic [ADDR_W-1:0] A_COND = ADDR_W'(SR_ADDR_COND);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(SR_ADDR_EN);
   localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(SR_ADDR_EVT);
   localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(SR_ADDR_FALL);
   localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(SR_ADDR_RISE);

   if (WIDTH < 1) begin : g_bad_width
      $error("stat_regset: WIDTH must be at least 1");
   end
   if (ADDR_W < SR_MIN_ADDR_W) begin : g_bad_addr
      $error("stat_regset: ADDR_W too small for the register map");
   end

   logic [WIDTH-1:0] cond_q;
   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] fall;
   logic [WIDTH-1:0] en_q;
   logic [WIDTH-1:0] rise_mask_q;
   logic [WIDTH-1:0] fall_mask_q;
   logic [WIDTH-1:0] ev_q;
   logic             clr_rd;

   stat_cond_track #(.WIDTH(WIDTH)) cond_i (
      .clk     (clk),
      .cond_in (cond_in),
      .cond_q  (cond_q),
      .rise    (rise),
      .fall    (fall)
   );

   stat_mask_reg #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SEL_ADDR(SR_ADDR_EN), .RESET_ONES(1'b0)
   ) en_i (
      .clk(clk), .sm_rst(sm_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .mask_q(en_q)
   );

   stat_mask_reg #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SEL_ADDR(SR_ADDR_FALL), .RESET_ONES(1'b0)
   ) fall_i (
      .clk(clk), .sm_rst(sm_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .mask_q(fall_mask_q)
   );

   stat_mask_reg #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SEL_ADDR(SR_ADDR_RISE), .RESET_ONES(1'b1)
   ) rise_i (
      .clk(clk), .sm_rst(sm_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .mask_q(rise_mask_q)
   );

   assign clr_rd = bus_rd && (bus_addr == A_EVT);

   stat_event_latch #(.WIDTH(WIDTH)) evt_i (
      .clk       (clk),
      .sm_rst    (sm_rst),
      .clr_rd    (clr_rd),
      .rise      (rise),
      .fall      (fall),
      .rise_mask (rise_mask_q),
      .fall_mask (fall_mask_q),
      .ev_q      (ev_q)
   );

   always_comb begin
      case (bus_addr)
         A_COND:  bus_rdata = cond_q;
         A_EN:    bus_rdata = en_q;
         A_EVT:   bus_rdata = ev_q;
         A_FALL:  bus_rdata = fall_mask_q;
         A_RISE:  bus_rdata = rise_mask_q;
         default: bus_rdata = '0;
      endcase
   end

   assign summary = |(ev_q & en_q);

endmodule

// File: rtl/stat_regset_chk.sv
module stat_regset_chk #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              sm_rst,
   input logic [WIDTH-1:0]  cond_in,
   input logic [WIDTH-1:0]  cond_q,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  ev_q,
   input logic [WIDTH-1:0]  en_q,
   input logic [WIDTH-1:0]  rise_q,
   input logic [WIDTH-1:0]  fall_q,
   input logic              summary
);

   localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(4);

   a_r1_cond_follows: assert property (@(posedge clk) disable iff (sm_rst)
      1'b1 |=> (cond_q == $past(cond_in)));

   a_r2_rise_latched: assert property (@(posedge clk) disable iff (sm_rst)
      (|(cond_in & ~cond_q & rise_q)) |=>
      ((ev_q & $past(cond_in & ~cond_q & rise_q)) == $past(cond_in & ~cond_q & rise_q)));

   a_r3_fall_latched: assert property (@(posedge clk) disable iff (sm_rst)
      (|(~cond_in & cond_q & fall_q)) |=>
      ((ev_q & $past(~cond_in & cond_q & fall_q)) == $past(~cond_in & cond_q & fall_q)));

   a_r4_event_held: assert property (@(posedge clk) disable iff (sm_rst)
      !(bus_rd && (bus_addr == A_EVT)) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

   a_r6_summary_idle: assert property (@(posedge clk) disable iff (sm_rst)
      ((en_q == '0) || (ev_q == '0)) |-> !summary);

   a_r7_read_clears: assert property (@(posedge clk) disable iff (sm_rst)
      (bus_rd && (bus_addr == A_EVT) && (cond_in == cond_q)) |=> (ev_q == '0));

   a_r8_reset_values: assert property (@(posedge clk) disable iff (sm_rst)
      $past(sm_rst) |-> ((ev_q == '0) && (en_q == '0) && (fall_q == '0) && (&rise_q)));

   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (sm_rst)
      (bus_addr > A_LAST) |-> (bus_rdata == '0));

endmodule

bind stat_regset stat_regset_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .sm_rst    (sm_rst),
   .cond_in   (cond_in),
   .cond_q    (cond_q),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .ev_q      (ev_q),
   .en_q      (en_q),
   .rise_q    (rise_mask_q),
   .fall_q    (fall_mask_q),
   .summary   (summary)
);

// File: tb/stat_regset_tb_top.sv
module stat_regset_tb_top;

   localparam int W  = 4;
   localparam int AW = 3;
   localparam int A_COND = 0, A_EN = 1, A_EVT = 2, A_FALL = 3, A_RISE = 4;

   logic          clk = 1'b0;
   logic          sm_rst;
   logic [W-1:0]  cond_in;
   logic [AW-1:0] bus_addr;
   logic          bus_wr, bus_rd;
   logic [W-1:0]  bus_wdata, bus_rdata;
   logic          summary;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [W-1:0] cur_cond;

   always #4 clk = ~clk;

   stat_regset #(.WIDTH(W), .ADDR_W(AW)) dut_i (
      .clk(clk), .sm_rst(sm_rst), .cond_in(cond_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .summary(summary)
   );

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic peek(input int a, output logic [W-1:0] v);
      @(negedge clk);
      bus_addr = AW'(a); bus_rd = 1'b0; bus_wr = 1'b0;
      #1 v = bus_rdata;
   endtask

   task automatic rd_strobe(input int a, output logic [W-1:0] v);
      @(negedge clk);
      bus_addr = AW'(a); bus_rd = 1'b1; bus_wr = 1'b0;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input int a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic set_cond(input logic [W-1:0] v);
      @(negedge clk);
      cond_in = v;
      cur_cond = v;
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v;
      sm_rst = 1'b1; cond_in = '0; cur_cond = '0;
      bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      sm_rst = 1'b0;

      // R8: reset state
      peek(A_EVT, v);  check("R8 event after reset", v, 4'h0);
      peek(A_EN, v);   check("R8 enable after reset", v, 4'h0);
      peek(A_FALL, v); check("R8 falling mask after reset", v, 4'h0);
      peek(A_RISE, v); check("R8 rising mask after reset", v, 4'hF);
      check("R8 summary after reset", {3'b0, summary}, 4'h0);

      // R1: condition register is one clock behind the inputs
      for (int c = 0; c < 16; c++) begin
         @(negedge clk);
         cond_in = W'(c); bus_addr = AW'(A_COND);
         #1 check("R1 condition before edge", bus_rdata, cur_cond);
         cur_cond = W'(c);
         peek(A_COND, v); check("R1 condition after edge", v, W'(c));
      end
      wr(A_COND, 4'hA);
      peek(A_COND, v); check("R1 write to condition ignored", v, cur_cond);

      // R10: mask readback
      for (int d = 0; d < 16; d++) begin
         wr(A_EN, W'(d));   peek(A_EN, v);   check("R10 enable readback", v, W'(d));
         wr(A_FALL, W'(d)); peek(A_FALL, v); check("R10 falling readback", v, W'(d));
         wr(A_RISE, W'(d)); peek(A_RISE, v); check("R10 rising readback", v, W'(d));
      end
      wr(A_EN, 4'h0);

      // R2 R3: exhaustive sweep over both direction masks
      for (int pm = 0; pm < 16; pm++) begin
         for (int nm = 0; nm < 16; nm++) begin
            wr(A_RISE, W'(pm));
            wr(A_FALL, W'(nm));
            rd_strobe(A_EVT, v);
            for (int s = 0; s < 16; s++) begin
               logic [W-1:0] prev, nxt, exp;
               prev = cur_cond;
               nxt  = W'((int'(prev) + 5 + s) % 16);
               exp  = (~prev & nxt & W'(pm)) | (prev & ~nxt & W'(nm));
               set_cond(nxt);
               rd_strobe(A_EVT, v);
               check("R2 R3 edge-qualified event", v, exp);
            end
         end
      end

      // R4: latching and what must not clear it
      wr(A_RISE, 4'hF); wr(A_FALL, 4'h0);
      set_cond(4'h0); rd_strobe(A_EVT, v);
      set_cond(4'h2);
      for (int k = 0; k < 4; k++) begin
         peek(A_EVT, v); check("R4 event held across peeks", v, 4'h2);
      end
      rd_strobe(A_EN, v); rd_strobe(A_COND, v);
      peek(A_EVT, v); check("R4 strobed read elsewhere keeps event", v, 4'h2);
      set_cond(4'h6);
      peek(A_EVT, v); check("R4 events accumulate", v, 4'h6);
      set_cond(4'h2);
      peek(A_EVT, v); check("R4 unselected falling edge leaves event", v, 4'h6);
      rd_strobe(A_EVT, v); check("R4 clearing read returns contents", v, 4'h6);
      peek(A_EVT, v); check("R4 cleared by read", v, 4'h0);

      // R5: event register is not writable
      set_cond(4'h0); rd_strobe(A_EVT, v);
      set_cond(4'h5);
      wr(A_EVT, 4'hA); peek(A_EVT, v); check("R5 write ones to event ignored", v, 4'h5);
      wr(A_EVT, 4'h0); peek(A_EVT, v); check("R5 write zero to event ignored", v, 4'h5);

      // R6: summary over every event and enable pattern
      for (int e = 0; e < 16; e++) begin
         set_cond(4'h0); rd_strobe(A_EVT, v);
         set_cond(W'(e));
         for (int en = 0; en < 16; en++) begin
            wr(A_EN, W'(en));
            #1 check("R6 summary", {3'b0, summary}, {3'b0, ((W'(e) & W'(en)) != 0)});
         end
      end
      wr(A_EN, 4'h0);

      // R7: clearing read and a new edge in the same cycle
      wr(A_RISE, 4'hF); wr(A_FALL, 4'hF);
      set_cond(4'h0); rd_strobe(A_EVT, v);
      set_cond(4'h1);
      @(negedge clk);
      cond_in = 4'h3; cur_cond = 4'h3;
      bus_addr = AW'(A_EVT); bus_rd = 1'b1;
      #1 check("R7 collision read returns old bits", bus_rdata, 4'h1);
      @(negedge clk);
      bus_rd = 1'b0;
      #1 check("R7 collision keeps only new bit", bus_rdata, 4'h2);

      // R9: unmapped addresses
      for (int a = 5; a < 8; a++) begin
         peek(a, v); check("R9 unmapped reads zero", v, 4'h0);
         wr(a, 4'h9);
      end
      peek(A_EN, v);   check("R9 enable untouched by unmapped write", v, 4'h0);
      peek(A_FALL, v); check("R9 falling untouched by unmapped write", v, 4'hF);
      peek(A_RISE, v); check("R9 rising untouched by unmapped write", v, 4'hF);

      // R8: reset wins over a write and ignores edges while held
      wr(A_EN, 4'hF); wr(A_FALL, 4'h5); wr(A_RISE, 4'h3);
      set_cond(4'h0); set_cond(4'hF);
      @(negedge clk);
      sm_rst = 1'b1; bus_addr = AW'(A_EN); bus_wdata = 4'hF; bus_wr = 1'b1;
      cond_in = 4'h0;
      @(negedge clk);
      cond_in = 4'h5; cur_cond = 4'h5;
      @(negedge clk);
      sm_rst = 1'b0; bus_wr = 1'b0;
      peek(A_EVT, v);  check("R8 event cleared, edges in reset ignored", v, 4'h0);
      peek(A_EN, v);   check("R8 reset beats enable write", v, 4'h0);
      peek(A_FALL, v); check("R8 falling mask reset", v, 4'h0);
      peek(A_RISE, v); check("R8 rising mask reset", v, 4'hF);
      peek(A_COND, v); check("R1 condition tracked through reset", v, 4'h5);
      check("R8 summary low after reset", {3'b0, summary}, 4'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule